// File: doc/BRIEF.md
# Accelerator Control Register Slave

This block is the register-mapped control point of a four-engine AES accelerator. A host reaches it through an AXI4-Lite slave port. Through that port it sets the cipher direction, the key-length code and up to eight 32-bit key words, and it reads a live busy/idle word for the four engines. The held settings drive the engines directly through plain output pins. Unused key words are forced to zero on those pins, so the engines see only the part of the key that belongs to the selected length.

Key expansion is the only job that needs a start/done handshake. The host sets the start bit in the control word. Start then stays high until the key-expansion-done input reports completion. At that point done and ready (ready always equals done) are raised and idle returns. Done holds until the host reads the control word, and that read clears it. Streamed encryption and decryption do not go through this handshake, and the block raises no interrupt.

Top module: `accel_ctrl_regs`

## Requirements
- R1: After reset, start_o, mode_o, key_len_o and key_o are all zero, no response is pending, and the control word reads 0x4 (only idle set).
- R2: A committed write to offset 0x00 with byte strobe 0 set and data bit 0 equal to 1 raises start_o and clears idle in the cycle the write commits. A write with bit 0 equal to 0 leaves start_o unchanged.
- R3: While a job runs (idle low), a high cycle of kexp_done_i clears start_o, sets idle and sets done at the next edge. A kexp_done_i while idle has no effect.
- R4: Done stays set until a read of offset 0x00 is accepted. That read still returns done=1, and later reads return done=0. Reads of other offsets leave done alone.
- R5: The control word layout is: bit 0 start, bit 1 done, bit 2 idle, bit 3 ready (equal to done), bit 4 continue (always reads 0). All other bits read 0.
- R6: Offset 0x10 bit 0 holds the direction (1 encrypt, 0 decrypt) and drives mode_o. Bits 31:1 read 0.
- R7: Offset 0x18 bits 1:0 hold the key-length code (00 = 128, 01 = 192, 10 = 256) and drive key_len_o. Bits 31:2 read 0.
- R8: Offset 0x20 reads eng_busy_i in bits 3:0 (bit i is engine i, 1 means busy). Writes to it are ignored.
- R9: Key word k (k = 7..0) sits at offset 0x28 + 8*(7-k), drives key_o[32k+31:32k], and is written byte by byte under the write strobes.
- R10: key_o carries zero in words 3..0 when the code is 00, in words 1..0 when the code is 01, and in no word for 10 or 11. The stored words still read back unchanged.
- R11: The write address and write data may arrive in either order or together. The register updates, and bvalid rises with bresp OKAY (00), one cycle after both are held.
- R12: Writes to undefined offsets are answered OKAY and change nothing. Reads of undefined offsets return 0 with OKAY.
- R13: rvalid rises one cycle after the read address is accepted. Read data stays stable while rvalid waits for rready, and arready stays low while a read response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response (always OKAY) |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response (always OKAY) |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| start_o | output | 1 | Key-expansion start |
| mode_o | output | 1 | 1 encrypt, 0 decrypt |
| key_len_o | output | 2 | Key-length code |
| key_o | output | 32*N_KEY | Key words, word k at bits 32k+31:32k, unused words zeroed |
| kexp_done_i | input | 1 | Key-expansion completion pulse |
| eng_busy_i | input | N_ENG | Per-engine busy flags |

## Verification
A write takes effect, and bvalid rises, one edge after the later of its address and data handshakes. The bench therefore checks that bvalid is still low at the first falling edge after the last handshake and high at the second, and it checks mode_o, key_len_o, key_o and start_o at that same second falling edge. Read data comes back one edge after the address is accepted: the read task queues the expected word right after the accepting edge, and a monitor compares it at the next falling edge, when rvalid is first high. A done pulse is checked on start_o and by readback at the falling edge that follows it.

// File: rtl/accel_ctrl_pkg.sv
`timescale 1ns/1ps
package accel_ctrl_pkg;
  localparam int unsigned REG_DW = 32;
  localparam int unsigned STRB_W = REG_DW / 8;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_MODE = 8'h10;
  localparam logic [7:0] OFS_KLEN = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_KEY_TOP = 8'h28;  // highest key word, lower words follow in steps of 8
  localparam logic [7:0] OFS_STEP = 8'h08;

  typedef enum logic [1:0] {
    KL_128 = 2'b00,
    KL_192 = 2'b01,
    KL_256 = 2'b10
  } key_len_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  function automatic logic [REG_DW-1:0] strb_merge(input logic [REG_DW-1:0] old_v,
                                                  input logic [REG_DW-1:0] new_v,
                                                  input logic [STRB_W-1:0] strb);
    logic [REG_DW-1:0] r;
    for (int b = 0; b < STRB_W; b++)
      r[8*b +: 8] = strb[b] ? new_v[8*b +: 8] : old_v[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/acr_wr_chan.sv
`timescale 1ns/1ps
module acr_wr_chan
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [REG_DW-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [REG_DW-1:0] wr_data_o,
  output logic [STRB_W-1:0] wr_strb_o
);
  logic aw_full_q, w_full_q, bvalid_q;

  assign awready_o = !aw_full_q;
  assign wready_o  = !w_full_q;
  assign bvalid_o  = bvalid_q;
  assign wr_en_o   = aw_full_q && w_full_q && !bvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      wr_strb_o <= '0;
    end else begin
      if (awvalid_i && !aw_full_q) begin
        aw_full_q <= 1'b1;
        wr_addr_o <= awaddr_i;
      end
      if (wvalid_i && !w_full_q) begin
        w_full_q  <= 1'b1;
        wr_data_o <= wdata_i;
        wr_strb_o <= wstrb_i;
      end
      if (wr_en_o) begin
        aw_full_q <= 1'b0;
        w_full_q  <= 1'b0;
        bvalid_q  <= 1'b1;
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acr_rd_chan.sv
`timescale 1ns/1ps
module acr_rd_chan
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [REG_DW-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [REG_DW-1:0] rd_data_i
);
  logic rvalid_q;

  assign arready_o = !rvalid_q;
  assign rvalid_o  = rvalid_q;
  assign rd_en_o   = arvalid_i && !rvalid_q;
  assign rd_addr_o = araddr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_o  <= '0;
    end else if (rd_en_o) begin
      rvalid_q <= 1'b1;
      rdata_o  <= rd_data_i;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acr_hs_ctrl.sv
`timescale 1ns/1ps
module acr_hs_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_req_i,
  input  logic ctrl_rd_i,
  input  logic kexp_done_i,
  output logic start_o,
  output logic done_o,
  output logic idle_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o <= 1'b0;
      done_o  <= 1'b0;
      idle_o  <= 1'b1;
    end else begin
      if (ctrl_rd_i) done_o <= 1'b0;  // read-to-clear; a completion in the same cycle wins
      if (start_req_i && idle_o) begin
        start_o <= 1'b1;
        idle_o  <= 1'b0;
      end else if (kexp_done_i && !idle_o) begin
        start_o <= 1'b0;
        idle_o  <= 1'b1;
        done_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/accel_ctrl_regs.sv
`timescale 1ns/1ps
module accel_ctrl_regs
  import accel_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned N_ENG  = 4,
  parameter int unsigned N_KEY  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       s_awaddr_i,
  input  logic                    s_awvalid_i,
  output logic                    s_awready_o,
  input  logic [REG_DW-1:0]       s_wdata_i,
  input  logic [STRB_W-1:0]       s_wstrb_i,
  input  logic                    s_wvalid_i,
  output logic                    s_wready_o,
  output logic [1:0]              s_bresp_o,
  output logic                    s_bvalid_o,
  input  logic                    s_bready_i,
  input  logic [ADDR_W-1:0]       s_araddr_i,
  input  logic                    s_arvalid_i,
  output logic                    s_arready_o,
  output logic [REG_DW-1:0]       s_rdata_o,
  output logic [1:0]              s_rresp_o,
  output logic                    s_rvalid_o,
  input  logic                    s_rready_i,
  output logic                    start_o,
  output logic                    mode_o,
  output logic [1:0]              key_len_o,
  output logic [REG_DW*N_KEY-1:0] key_o,
  input  logic                    kexp_done_i,
  input  logic [N_ENG-1:0]        eng_busy_i
);
  localparam int unsigned KEY_W192 = N_KEY - 6;  // words below this index unused at 192 bits
  localparam int unsigned KEY_W128 = N_KEY - 4;  // words below this index unused at 128 bits

  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [REG_DW-1:0] wr_data, rd_data;
  logic [STRB_W-1:0] wr_strb;
  logic              hs_done, hs_idle;
  logic [REG_DW-1:0] key_q [N_KEY];
  logic [1:0]        klen_q;
  logic              mode_q;

  acr_wr_chan #(.ADDR_W(ADDR_W)) u_wr (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_strb_o(wr_strb)
  );

  acr_rd_chan #(.ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni,
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
  );

  assign s_bresp_o = RESP_OKAY;
  assign s_rresp_o = RESP_OKAY;

  logic start_req, ctrl_rd;
  assign start_req = wr_en && (wr_addr == ADDR_W'(OFS_CTRL)) && wr_strb[0] && wr_data[0];
  assign ctrl_rd   = rd_en && (rd_addr == ADDR_W'(OFS_CTRL));

  acr_hs_ctrl u_hs (
    .clk_i, .rst_ni,
    .start_req_i(start_req), .ctrl_rd_i(ctrl_rd), .kexp_done_i(kexp_done_i),
    .start_o(start_o), .done_o(hs_done), .idle_o(hs_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      klen_q <= KL_128;
    end else if (wr_en && wr_strb[0]) begin
      if (wr_addr == ADDR_W'(OFS_MODE)) mode_q <= wr_data[0];
      if (wr_addr == ADDR_W'(OFS_KLEN)) klen_q <= wr_data[1:0];
    end
  end

  assign mode_o    = mode_q;
  assign key_len_o = klen_q;

  for (genvar k = 0; k < N_KEY; k++) begin : g_key
    localparam logic [ADDR_W-1:0] KOFS = ADDR_W'(OFS_KEY_TOP + OFS_STEP * (N_KEY - 1 - k));
    logic keep;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) key_q[k] <= '0;
      else if (wr_en && wr_addr == KOFS) key_q[k] <= strb_merge(key_q[k], wr_data, wr_strb);
    end

    always_comb begin
      unique case (klen_q)
        KL_128:  keep = (k >= KEY_W128);
        KL_192:  keep = (k >= KEY_W192);
        default: keep = 1'b1;
      endcase
    end

    assign key_o[REG_DW*k +: REG_DW] = keep ? key_q[k] : '0;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(OFS_CTRL))      rd_data[4:0] = {1'b0, hs_done, hs_idle, hs_done, start_o};
    else if (rd_addr == ADDR_W'(OFS_MODE)) rd_data[0]   = mode_q;
    else if (rd_addr == ADDR_W'(OFS_KLEN)) rd_data[1:0] = klen_q;
    else if (rd_addr == ADDR_W'(OFS_STAT)) rd_data[N_ENG-1:0] = eng_busy_i;
    else begin
      for (int k = 0; k < N_KEY; k++)
        if (rd_addr == ADDR_W'(OFS_KEY_TOP + OFS_STEP * (N_KEY - 1 - k))) rd_data = key_q[k];
    end
  end
endmodule

// File: rtl/accel_ctrl_regs_chk.sv
`timescale 1ns/1ps
module accel_ctrl_regs_chk #(
  parameter int unsigned N_KEY = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                s_awvalid_i,
  input logic                s_awready_o,
  input logic                s_wvalid_i,
  input logic                s_wready_o,
  input logic                s_bvalid_o,
  input logic                s_bready_i,
  input logic [1:0]          s_bresp_o,
  input logic                s_arready_o,
  input logic                s_rvalid_o,
  input logic                s_rready_i,
  input logic [31:0]         s_rdata_o,
  input logic                start_o,
  input logic                kexp_done_i,
  input logic [1:0]          key_len_o,
  input logic [32*N_KEY-1:0] key_o,
  input logic                done_i,
  input logic                idle_i
);
  assert_start_not_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !idle_i);
  assert_start_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o && !kexp_done_i |=> start_o);
  assert_done_drops_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> !start_o && idle_i);
  assert_key_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_len_o == 2'b00 |-> key_o[32*(N_KEY-4)-1:0] == '0);
  assert_aw_one_shot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_awvalid_i && s_awready_o |=> !s_awready_o);
  assert_w_one_shot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_wvalid_i && s_wready_o |=> !s_wready_o);
  assert_bvalid_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o && !s_bready_i |=> s_bvalid_o);
  assert_bresp_okay_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_bvalid_o |-> s_bresp_o == 2'b00);
  assert_rdata_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o && !s_rready_i |=> s_rvalid_o && $stable(s_rdata_o));
  assert_ar_block_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_rvalid_o |-> !s_arready_o);
endmodule

bind accel_ctrl_regs accel_ctrl_regs_chk #(.N_KEY(N_KEY)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .s_awvalid_i(s_awvalid_i), .s_awready_o(s_awready_o),
  .s_wvalid_i(s_wvalid_i), .s_wready_o(s_wready_o),
  .s_bvalid_o(s_bvalid_o), .s_bready_i(s_bready_i), .s_bresp_o(s_bresp_o),
  .s_arready_o(s_arready_o), .s_rvalid_o(s_rvalid_o), .s_rready_i(s_rready_i),
  .s_rdata_o(s_rdata_o), .start_o(start_o), .kexp_done_i(kexp_done_i),
  .key_len_o(key_len_o), .key_o(key_o), .done_i(hs_done), .idle_i(hs_idle)
);

// File: tb/accel_ctrl_regs_test.sv
`timescale 1ns/1ps
module accel_ctrl_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = !clk;

  logic [7:0]   awaddr = '0, araddr = '0;
  logic         awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0]  wdata = '0;
  logic [3:0]   wstrb = '0;
  logic         kexp_done = 0;
  logic [3:0]   eng_busy = '0;
  logic         awready, wready, bvalid, arready, rvalid, start, mode;
  logic [1:0]   bresp, rresp, key_len;
  logic [31:0]  rdata;
  logic [255:0] key;

  accel_ctrl_regs uut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(1'b1),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(1'b1),
    .start_o(start), .mode_o(mode), .key_len_o(key_len), .key_o(key),
    .kexp_done_i(kexp_done), .eng_busy_i(eng_busy)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] kw[8];

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // read monitor: compares each returned word against the scoreboard
  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) check("R13 unexpected rvalid", 1, 0);
      else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, {rresp, rdata}, {2'b00, e});
      end
    end
  end

  task automatic axi_rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    araddr = a; arvalid = 1;
    while (!arready) @(negedge clk);
    @(posedge clk);
    exp_q.push_back(e); tag_q.push_back(req);
    @(negedge clk);
    arvalid = 0;
  endtask

  task automatic send_aw(input logic [7:0] a);
    awaddr = a; awvalid = 1;
    while (!awready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    awvalid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s);
    wdata = d; wstrb = s; wvalid = 1;
    while (!wready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    wvalid = 0;
  endtask

  // order 0: together, 1: address first, 2: data first
  task automatic axi_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                        input int order, input string req);
    @(negedge clk);
    if (order == 0) begin
      awaddr = a; awvalid = 1; wdata = d; wstrb = s; wvalid = 1;
      while (!(awready && wready)) @(negedge clk);
      @(posedge clk); @(negedge clk);
      awvalid = 0; wvalid = 0;
    end else if (order == 1) begin
      send_aw(a); @(negedge clk); send_w(d, s);
    end else begin
      send_w(d, s); @(negedge clk); send_aw(a);
    end
    check({req, " R11 bvalid early"}, bvalid, 0);
    @(negedge clk);
    check({req, " R11 bvalid/bresp"}, {bvalid, bresp}, {1'b1, 2'b00});
  endtask

  function automatic logic [7:0] kofs(input int k);
    return 8'h28 + 8'(8 * (7 - k));
  endfunction

  function automatic logic [255:0] exp_key(input logic [1:0] len);
    logic [255:0] r;
    for (int k = 0; k < 8; k++) begin
      bit keep = (len == 2'b00) ? (k >= 4) : (len == 2'b01) ? (k >= 2) : 1'b1;
      r[32*k +: 32] = keep ? kw[k] : 32'h0;
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 outputs", {start, mode, key_len, key, bvalid, rvalid}, '0);
    axi_rd(8'h00, 32'h4, "R1 R5 ctrl after reset");

    // R6 direction
    axi_wr(8'h10, 32'h1, 4'hF, 0, "R6");
    check("R6 mode_o", mode, 1);
    axi_wr(8'h10, 32'hFFFF_FFFF, 4'hF, 2, "R6");
    axi_rd(8'h10, 32'h1, "R6 upper bits zero");

    // R7 key length, address first
    axi_wr(8'h18, 32'h2, 4'hF, 1, "R7");
    check("R7 key_len_o", key_len, 2'b10);
    axi_rd(8'h18, 32'h2, "R7 readback");

    // R9 key words, mixed channel order
    for (int k = 0; k < 8; k++) begin
      kw[k] = 32'hC0DE_0000 | 32'(k * 32'h0101);
      axi_wr(kofs(k), kw[k], 4'hF, k % 3, "R9");
    end
    check("R9 key_o full", key, exp_key(2'b10));
    axi_wr(kofs(7), 32'h0000_00AA, 4'b0001, 0, "R9");
    kw[7] = 32'hC0DE_07AA;
    axi_wr(kofs(6), 32'h55FF_FFFF, 4'b1000, 2, "R9");
    kw[6] = 32'h55DE_0606;
    axi_rd(kofs(7), kw[7], "R9 strobe byte0");
    axi_rd(kofs(6), kw[6], "R9 strobe byte3");
    check("R9 key_o after strobes", key, exp_key(2'b10));

    // R10 masking by length code
    axi_wr(8'h18, 32'h0, 4'hF, 0, "R10");
    check("R10 key_o 128", key, exp_key(2'b00));
    axi_rd(kofs(0), kw[0], "R10 hidden word reads back");
    axi_wr(8'h18, 32'h1, 4'hF, 1, "R10");
    check("R10 key_o 192", key, exp_key(2'b01));
    axi_wr(8'h18, 32'h3, 4'hF, 0, "R10");
    check("R10 key_o code 11", key, exp_key(2'b11));

    // R8 status
    eng_busy = 4'b1010;
    axi_rd(8'h20, 32'hA, "R8 status");
    axi_wr(8'h20, 32'hF, 4'hF, 0, "R8");
    eng_busy = 4'b0110;
    axi_rd(8'h20, 32'h6, "R8 status after write");

    // R12 undefined offsets
    axi_wr(8'h70, 32'hDEAD_BEEF, 4'hF, 0, "R12");
    axi_rd(8'h70, 32'h0, "R12 undefined read");
    axi_rd(8'h14, 32'h0, "R12 hole read");
    check("R12 outputs untouched", {mode, key_len, key}, {1'b1, 2'b11, exp_key(2'b11)});

    // R2..R4 handshake
    axi_wr(8'h00, 32'h1, 4'h1, 0, "R2");
    check("R2 start_o set", start, 1);
    axi_rd(8'h00, 32'h1, "R2 R5 ctrl running");
    axi_wr(8'h00, 32'h0, 4'h1, 1, "R2");
    check("R2 start held after zero write", start, 1);
    @(negedge clk); kexp_done = 1;
    @(negedge clk); kexp_done = 0;
    check("R3 start_o cleared", start, 0);
    axi_rd(8'h10, 32'h1, "R4 other read");
    axi_rd(8'h00, 32'hE, "R4 R5 done ready idle");
    axi_rd(8'h00, 32'h4, "R4 done cleared by read");
    @(negedge clk); kexp_done = 1;
    @(negedge clk); kexp_done = 0;
    check("R3 stray done start_o", start, 0);
    axi_rd(8'h00, 32'h4, "R3 stray done ignored");

    repeat (4) @(negedge clk);
    check("R13 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule